// File: doc/BRIEF.md
# Ping-pong dual-SRAM frame buffer controller

This block takes a continuous stream of 8-bit pixel bytes, qualified by a valid strobe, and stores whole images into two external asynchronous SRAMs in alternation. While one SRAM is being filled, the other SRAM is cut off from the writer. A bus-isolation control hands that SRAM to a downstream processor, which can then read the previous image at its own pace.

Each SRAM has its own write address counter of `ADDR_W` (19) bits, which covers a 512 KB device. A byte that is accepted appears on the active SRAM one clock later as a registered address, data and active-low write pulse. After `FRAME_PIXELS` bytes the frame is complete. The block then raises a one-clock interrupt and reports which SRAM holds the new image. It ignores further bytes until the next rising edge of the frame-start input. On that edge it swaps the roles of the two SRAMs and restarts the new target's address at zero. The SRAMs have only a chip enable and a write enable, because the block never reads them.

Top module: `fb_pingpong`

## Requirements
- R1: After reset, SRAM A is the write target, both address counters are zero, `irq` is 0, `irq_bank` is 0, both write enables are high, `iso_a` is 0 and `iso_b` is 1.
- R2: A clock edge with `pix_valid` high in a frame that is not yet complete is an accepted byte. For the following clock, the active SRAM shows write enable low, the address equal to its counter value before the edge, and the accepted byte on the data bus. Only the active SRAM's counter then advances by one.
- R3: A clock edge with `pix_valid` low produces no write: the write enable is high for the next cycle, and the active SRAM's address and data keep their previous values.
- R4: When the byte written to address `FRAME_PIXELS-1` is accepted, `irq` is 1 for exactly the one following cycle. In that same cycle `irq_bank` changes to the SRAM that was filled (0 = A, 1 = B). From then on valid bytes are ignored and produce no write until the swap.
- R5: The target SRAM swaps only on a clock edge that sees a rising edge of `frame_start` while the frame is complete. A rising edge of `frame_start` in an incomplete frame has no effect. A valid byte on the swap edge is ignored.
- R6: On a swap, the new target SRAM's address counter restarts, so that its first accepted byte is written at address 0.
- R7: For the idle SRAM, the address, data and chip enable are at high impedance, the write enable is high, and its isolation output (`iso_a` or `iso_b`) is 1, which connects it to the processor. For the active SRAM, the chip enable is low and its isolation output is 0.
- R8: The active-low `rst_n` acts asynchronously. Driving it low returns the state of R1 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel byte valid strobe |
| frame_start | input | 1 | Frame-start indication; its rising edge is used |
| pix_data | input | 8 | Pixel byte |
| sram_a_data | output | 8 | SRAM A data, high impedance when idle |
| sram_a_addr | output | 19 | SRAM A address, high impedance when idle |
| sram_a_ce_n | output | 1 | SRAM A chip enable, active low, high impedance when idle |
| sram_a_we_n | output | 1 | SRAM A write enable, active low |
| sram_b_data | output | 8 | SRAM B data, high impedance when idle |
| sram_b_addr | output | 19 | SRAM B address, high impedance when idle |
| sram_b_ce_n | output | 1 | SRAM B chip enable, active low, high impedance when idle |
| sram_b_we_n | output | 1 | SRAM B write enable, active low |
| iso_a | output | 1 | 1 connects SRAM A to the processor and isolates the writer |
| iso_b | output | 1 | 1 connects SRAM B to the processor and isolates the writer |
| irq | output | 1 | One-cycle frame-complete pulse |
| irq_bank | output | 1 | SRAM holding the last completed frame (0 = A, 1 = B) |

## Verification
The bench pulses `frame_start` in the middle of a frame. A design that swapped on any edge would split an image across both SRAMs. It also sends valid bytes after the frame is complete and on the swap edge itself. A design that took them would write past the frame or leave a stray byte at address 0 of the new SRAM. By running two full ping-pong rounds, it catches a counter that is not cleared on a swap, which would start at the previous frame's end. It also catches an `irq_bank` that names the new target instead of the filled SRAM. Finally, it applies reset between clock edges, which exposes a reset that waits for the clock.

// File: rtl/fb_pkg.sv
package fb_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 19;
    localparam int NBANK  = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              we_n;
    } wr_beat_t;

    function automatic bank_e other_bank(bank_e b);
        return bank_e'(~b);
    endfunction

endpackage

// File: rtl/fb_addr_ctr.sv
module fb_addr_ctr #(
    parameter int ADDR_W = fb_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fb_bank_ctrl.sv
module fb_bank_ctrl
    import fb_pkg::*;
#(
    parameter int ADDR_W       = fb_pkg::ADDR_W,
    parameter int FRAME_PIXELS = 101376
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] cur_cnt,
    output bank_e             sel,
    output logic              accept,
    output logic              swap,
    output logic              done,
    output logic              irq,
    output bank_e             irq_bank
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_PIXELS - 1);

    logic fs_q;
    logic fs_rise;
    logic last_beat;

    assign fs_rise   = frame_start & ~fs_q;
    assign swap      = done & fs_rise;
    assign accept    = pix_valid & ~done;
    assign last_beat = accept && (cur_cnt == LAST_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q     <= 1'b0;
            sel      <= BANK_A;
            done     <= 1'b0;
            irq      <= 1'b0;
            irq_bank <= BANK_A;
        end else begin
            fs_q <= frame_start;
            irq  <= last_beat;
            if (swap) begin
                sel  <= other_bank(sel);
                done <= 1'b0;
            end else if (last_beat) begin
                done     <= 1'b1;
                irq_bank <= sel;
            end
        end
    end

    AST_SWAP_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> $past(done)); // R5

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R4

endmodule

// File: rtl/fb_port_drv.sv
module fb_port_drv
    import fb_pkg::*;
#(
    parameter int DATA_W = fb_pkg::DATA_W,
    parameter int ADDR_W = fb_pkg::ADDR_W
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              beat_we_n,
    output logic [DATA_W-1:0] sram_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              iso
);

    assign sram_addr = active ? beat_addr : {ADDR_W{1'bz}};
    assign sram_data = active ? beat_data : {DATA_W{1'bz}};
    assign sram_ce_n = active ? 1'b0 : 1'bz;
    assign sram_we_n = active ? beat_we_n : 1'b1;
    assign iso       = ~active;

endmodule

// File: rtl/fb_pingpong.sv
module fb_pingpong
    import fb_pkg::*;
#(
    parameter int FRAME_PIXELS = 101376
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              frame_start,
    input  logic [DATA_W-1:0] pix_data,
    output logic [DATA_W-1:0] sram_a_data,
    output logic [ADDR_W-1:0] sram_a_addr,
    output logic              sram_a_ce_n,
    output logic              sram_a_we_n,
    output logic [DATA_W-1:0] sram_b_data,
    output logic [ADDR_W-1:0] sram_b_addr,
    output logic              sram_b_ce_n,
    output logic              sram_b_we_n,
    output logic              iso_a,
    output logic              iso_b,
    output logic              irq,
    output logic              irq_bank
);

    bank_e             sel;
    bank_e             irq_bank_e;
    logic              accept;
    logic              swap;
    logic              done;
    logic [ADDR_W-1:0] cnt [NBANK];
    logic [ADDR_W-1:0] cur_cnt;
    wr_beat_t          beat_q;

    assign cur_cnt  = cnt[int'(sel)];
    assign irq_bank = irq_bank_e;

    fb_bank_ctrl #(
        .ADDR_W       (ADDR_W),
        .FRAME_PIXELS (FRAME_PIXELS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .frame_start (frame_start),
        .cur_cnt     (cur_cnt),
        .sel         (sel),
        .accept      (accept),
        .swap        (swap),
        .done        (done),
        .irq         (irq),
        .irq_bank    (irq_bank_e)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_ctr
        logic bank_inc;
        logic bank_clr;
        assign bank_inc = accept && (int'(sel) == i);
        assign bank_clr = swap && (int'(other_bank(sel)) == i);
        fb_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (bank_clr),
            .inc   (bank_inc),
            .cnt   (cnt[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q.addr <= '0;
            beat_q.data <= '0;
            beat_q.we_n <= 1'b1;
        end else begin
            beat_q.we_n <= ~accept;
            if (accept) begin
                beat_q.addr <= cur_cnt;
                beat_q.data <= pix_data;
            end
        end
    end

    fb_port_drv #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drv_a (
        .active    (sel == BANK_A),
        .beat_addr (beat_q.addr),
        .beat_data (beat_q.data),
        .beat_we_n (beat_q.we_n),
        .sram_data (sram_a_data),
        .sram_addr (sram_a_addr),
        .sram_ce_n (sram_a_ce_n),
        .sram_we_n (sram_a_we_n),
        .iso       (iso_a)
    );

    fb_port_drv #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drv_b (
        .active    (sel == BANK_B),
        .beat_addr (beat_q.addr),
        .beat_data (beat_q.data),
        .beat_we_n (beat_q.we_n),
        .sram_data (sram_b_data),
        .sram_addr (sram_b_addr),
        .sram_ce_n (sram_b_ce_n),
        .sram_we_n (sram_b_we_n),
        .iso       (iso_b)
    );

    AST_IDLE_QUIET_A: assert property (@(posedge clk) disable iff (!rst_n)
        iso_a |-> sram_a_we_n); // R7

    AST_IDLE_QUIET_B: assert property (@(posedge clk) disable iff (!rst_n)
        iso_b |-> sram_b_we_n); // R7

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> beat_q.we_n); // R4

    AST_IRQ_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !beat_q.we_n); // R4

endmodule

// File: tb/fb_pingpong_tb.sv
`timescale 1ns/1ps
module fb_pingpong_tb;

    localparam int FP = 4;
    localparam int NV = 18;

    typedef struct packed {
        logic       v;
        logic       fs;
        logic [7:0] d;
        logic       bank;
        logic       chk;
        logic [7:0] ea;
        logic [7:0] ed;
        logic       we;
        logic       irq;
        logic       irqb;
    } vec_t;

    // v fs d bank chk addr data we_n irq irq_bank
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 8'd10, 1'b0, 1'b1, 8'd0, 8'd10, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd11, 1'b0, 1'b1, 8'd1, 8'd11, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'd0,  1'b0, 1'b1, 8'd1, 8'd11, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 8'd12, 1'b0, 1'b1, 8'd2, 8'd12, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd13, 1'b0, 1'b1, 8'd3, 8'd13, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 8'd99, 1'b0, 1'b1, 8'd3, 8'd13, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 8'd77, 1'b1, 1'b0, 8'd0, 8'd0,  1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd20, 1'b1, 1'b1, 8'd0, 8'd20, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd21, 1'b1, 1'b1, 8'd1, 8'd21, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd22, 1'b1, 1'b1, 8'd2, 8'd22, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd23, 1'b1, 1'b1, 8'd3, 8'd23, 1'b0, 1'b1, 1'b1},
        '{1'b0, 1'b1, 8'd0,  1'b0, 1'b0, 8'd0, 8'd0,  1'b1, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'd30, 1'b0, 1'b1, 8'd0, 8'd30, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'd31, 1'b0, 1'b1, 8'd1, 8'd31, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'd32, 1'b0, 1'b1, 8'd2, 8'd32, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 8'd33, 1'b0, 1'b1, 8'd3, 8'd33, 1'b0, 1'b1, 1'b0},
        '{1'b0, 1'b1, 8'd0,  1'b1, 1'b0, 8'd0, 8'd0,  1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd40, 1'b1, 1'b1, 8'd0, 8'd40, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_valid;
    logic        frame_start;
    logic [7:0]  pix_data;
    wire  [7:0]  a_data, b_data;
    wire  [18:0] a_addr, b_addr;
    wire         a_ce_n, b_ce_n, a_we_n, b_we_n;
    wire         iso_a, iso_b, irq, irq_bank;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fb_pingpong #(.FRAME_PIXELS(FP)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .frame_start (frame_start),
        .pix_data    (pix_data),
        .sram_a_data (a_data),
        .sram_a_addr (a_addr),
        .sram_a_ce_n (a_ce_n),
        .sram_a_we_n (a_we_n),
        .sram_b_data (b_data),
        .sram_b_addr (b_addr),
        .sram_b_ce_n (b_ce_n),
        .sram_b_we_n (b_we_n),
        .iso_a       (iso_a),
        .iso_b       (iso_b),
        .irq         (irq),
        .irq_bank    (irq_bank)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_bank(input string req, input logic bank, input logic chk_ad,
                            input logic [7:0] ea, input logic [7:0] ed,
                            input logic we, input logic eirq, input logic eirqb);
        chk("R7", "iso_a", 32'(iso_a), 32'(bank));
        chk("R7", "iso_b", 32'(iso_b), 32'(!bank));
        chk("R7", "idle we_n", 32'(bank ? a_we_n : b_we_n), 32'd1);
        chk("R7", "active ce_n", 32'(bank ? b_ce_n : a_ce_n), 32'd0);
        chk(req, "active we_n", 32'(bank ? b_we_n : a_we_n), 32'(we));
        chk("R4", "irq", 32'(irq), 32'(eirq));
        chk("R4", "irq_bank", 32'(irq_bank), 32'(eirqb));
        if (chk_ad) begin
            chk(req, "addr", 32'(bank ? b_addr : a_addr), 32'(ea));
            chk(req, "data", 32'(bank ? b_data : a_data), 32'(ed));
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n       = 1'b0;
        pix_valid   = 1'b0;
        frame_start = 1'b0;
        pix_data    = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_bank("R1", 1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0);
        chk("R1", "b we_n", 32'(b_we_n), 32'd1);

        // R2 R3 R4 R5 R6: vector table, one row per clock
        for (int i = 0; i < NV; i++) begin
            pix_valid   = VEC[i].v;
            frame_start = VEC[i].fs;
            pix_data    = VEC[i].d;
            @(negedge clk);
            if (i == 2 || i == 5)
                chk_bank("R3", VEC[i].bank, VEC[i].chk, VEC[i].ea, VEC[i].ed,
                         VEC[i].we, VEC[i].irq, VEC[i].irqb);
            else if (i == 6 || i == 11 || i == 16)
                chk_bank("R5", VEC[i].bank, VEC[i].chk, VEC[i].ea, VEC[i].ed,
                         VEC[i].we, VEC[i].irq, VEC[i].irqb);
            else if (i == 7 || i == 12 || i == 17)
                chk_bank("R6", VEC[i].bank, VEC[i].chk, VEC[i].ea, VEC[i].ed,
                         VEC[i].we, VEC[i].irq, VEC[i].irqb);
            else
                chk_bank("R2", VEC[i].bank, VEC[i].chk, VEC[i].ea, VEC[i].ed,
                         VEC[i].we, VEC[i].irq, VEC[i].irqb);
        end

        // R8: asynchronous reset between clock edges, B active beforehand
        pix_valid   = 1'b0;
        frame_start = 1'b0;
        #2;
        rst_n = 1'b0;
        #3;
        chk("R8", "iso_a", 32'(iso_a), 32'd0);
        chk("R8", "iso_b", 32'(iso_b), 32'd1);
        chk("R8", "a we_n", 32'(a_we_n), 32'd1);
        chk("R8", "irq_bank", 32'(irq_bank), 32'd0);
        @(negedge clk);
        rst_n     = 1'b1;
        pix_valid = 1'b1;
        pix_data  = 8'd50;
        @(negedge clk);
        // R8 R1: counter cleared, first byte at address 0 of A
        chk_bank("R8", 1'b0, 1'b1, 8'd0, 8'd50, 1'b0, 1'b0, 1'b0);
        pix_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule